// File: doc/BRIEF.md
# Device Identity CRC-8 Checker

This block checks a 64-bit device identity word that arrives one bit at a time. The word starts with an 8-bit family code, followed by a 48-bit serial number and then an 8-bit check byte. All fields are sent least significant bit first. A start pulse clears the checksum register and the bit count. Each bit strobe then folds the data bit into the register, using the generator x^8 + x^5 + x^4 + 1 in its reflected, right-shifting form.

After the first 56 bits, the register holds the check byte that the sender should have appended. The block validates the word by residue: once the check byte has also been shifted in, a consistent word leaves the register at zero. On the 64th accepted bit the block raises a done flag, and raises a valid flag when the residue is zero. Both flags hold until the next start. Strobes that arrive after the 64th bit are ignored.

Top module: `crc8id_checker`

## Requirements
- R1: During and after a synchronous reset (`rst` high), with no strobe since, `crc_o` is 8'h00 and `done_o` and `valid_o` are 0. The block is then ready to count bits from zero, as after a start.
- R2: Each accepted strobe updates the register as follows: fb = crc[0] XOR bit_i, then the register shifts right by one with fb entering bit 7, then bits 3 and 2 are XORed with fb. This is the reflected form of x^8+x^5+x^4+1, mask 8'h8C. The new value appears on `crc_o` in the cycle after the strobe's clock edge.
- R3: After 56 accepted bits, starting from a cleared register, `crc_o` equals the CRC-8 of those 56 bits.
- R4: The 64th accepted bit sets `done_o` from the next cycle. `valid_o` is set along with it only if the register after that bit is 8'h00.
- R5: Once 64 bits have been accepted, further strobes leave `crc_o`, `done_o` and `valid_o` unchanged until the next start.
- R6: A start pulse clears the register, the bit count, `done_o` and `valid_o` in the next cycle, including in the middle of a word. Counting then restarts at bit 0.
- R7: A strobe in the same cycle as a start pulse is not counted and does not change the register.
- R8: In a cycle with neither strobe nor start, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new identity word |
| bit_stb_i | input | 1 | Data bit qualifier, one bit per cycle high |
| bit_i | input | 1 | Serial data bit, least significant first |
| crc_o | output | 8 | Running checksum register |
| done_o | output | 1 | All 64 bits received |
| valid_o | output | 1 | Word received with zero residue |

## Verification
Each strobe or start sampled at a rising edge shows up on `crc_o`, `done_o` and `valid_o` right after that same edge. That means one cycle of latency, with no further pipeline. The bench drives inputs shortly after each rising edge and compares all three outputs at the following falling edge against a behavioural model that advances on the same edge. Dedicated checks at the 56th and 64th bit confirm the expected check byte and the flag timing. The test words include good ones, a corrupted one and an all-zero one. Restarts in the middle of a word, a start coinciding with a strobe, gaps between strobes and strobes beyond the 64th bit are all covered.

// File: rtl/crc8id_pkg.sv
package crc8id_pkg;
  localparam int ID_BITS  = 64;
  localparam int CRC_W    = 8;
  // Normal-form low-order taps of x^8+x^5+x^4+1 (x^8 implied)
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h31;
endpackage

// File: rtl/crc8id_lfsr.sv
module crc8id_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] POLY = 8'h31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] nxt_o,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] refl;
  logic         fb;

  assign fb = crc_o[0] ^ din;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_tap
      assign refl[g] = POLY[W-1-g];
      if (g == W-1) begin : g_top
        assign nxt_o[g] = fb & refl[g];
      end else begin : g_mid
        assign nxt_o[g] = crc_o[g+1] ^ (fb & refl[g]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr)
      crc_o <= '0;
    else if (en)
      crc_o <= nxt_o;
  end

  // R2: with a zero feedback bit the update is a plain right shift
  p_plain_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && !(crc_o[0] ^ din)) |=> (crc_o == ($past(crc_o) >> 1)));

  // R8: no enable and no clear keeps the register
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(crc_o));
endmodule

// File: rtl/crc8id_bitcnt.sv
module crc8id_bitcnt #(
  parameter int N  = 64,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          stb,
  output logic          accept_o,
  output logic          last_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LIMIT = CW'(N);
  localparam logic [CW-1:0] FINAL = CW'(N - 1);

  assign accept_o = stb && !clr && (cnt_o < LIMIT);
  assign last_o   = accept_o && (cnt_o == FINAL);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_o <= '0;
    else if (accept_o)
      cnt_o <= cnt_o + 1'b1;
  end

  // R5: the count never runs past the word length
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= LIMIT);

  // R6: a clear restarts the count at zero
  p_clear_count_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_o == '0));
endmodule

// File: rtl/crc8id_checker.sv
module crc8id_checker
  import crc8id_pkg::*;
#(
  parameter int ID_W = ID_BITS,
  parameter int CW   = CRC_W,
  parameter logic [CW-1:0] POLY = CRC_POLY
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          bit_stb_i,
  input  logic          bit_i,
  output logic [CW-1:0] crc_o,
  output logic          done_o,
  output logic          valid_o
);
  localparam int CNT_W = $clog2(ID_W + 1);

  logic             accept;
  logic             last;
  logic [CNT_W-1:0] cnt;
  logic [CW-1:0]    crc_nxt;

  crc8id_bitcnt #(.N(ID_W), .CW(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (start_i),
    .stb      (bit_stb_i),
    .accept_o (accept),
    .last_o   (last),
    .cnt_o    (cnt)
  );

  crc8id_lfsr #(.W(CW), .POLY(POLY)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .clr   (start_i),
    .en    (accept),
    .din   (bit_i),
    .nxt_o (crc_nxt),
    .crc_o (crc_o)
  );

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      done_o  <= 1'b0;
      valid_o <= 1'b0;
    end else if (last) begin
      done_o  <= 1'b1;
      valid_o <= (crc_nxt == '0);
    end
  end

  // R4: validity implies completion and a zero residue
  p_valid_zero_r4: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (done_o && crc_o == '0));

  // R4: done is only raised once the full word has been counted
  p_done_count_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (cnt == CNT_W'(ID_W)));

  // R5: after completion, strobes change nothing until a start
  p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(crc_o) && $stable(valid_o)));

  // R6: start clears every output
  p_start_clears_r6: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (crc_o == '0 && !done_o && !valid_o));
endmodule

// File: tb/sim_crc8id_checker.sv
module sim_crc8id_checker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       bit_stb_i = 1'b0;
  logic       bit_i = 1'b0;
  logic [7:0] crc_o;
  logic       done_o;
  logic       valid_o;

  crc8id_checker u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .bit_stb_i(bit_stb_i),
    .bit_i(bit_i), .crc_o(crc_o), .done_o(done_o), .valid_o(valid_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    n_tests = 0;
  int    n_fail  = 0;
  string req     = "R1";
  bit    ended   = 1'b0;

  // behavioural reference state
  int         m_cnt  = 0;
  logic [7:0] m_crc  = 8'h00;
  bit         m_done = 1'b0;
  bit         m_val  = 1'b0;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input bit b);
    int v;
    v = int'(c);
    if (((v & 1) != 0) != b) v = (v >> 1) ^ 'h8C;
    else                     v = v >> 1;
    return v[7:0];
  endfunction

  function automatic logic [7:0] crc_of(input logic [63:0] w, input int nbits);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < nbits; i++) c = crc_step(c, w[i]);
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst || start_i) begin
      m_cnt = 0; m_crc = 8'h00; m_done = 1'b0; m_val = 1'b0;
    end else if (bit_stb_i && m_cnt < 64) begin
      m_crc = crc_step(m_crc, bit_i);
      m_cnt++;
      if (m_cnt == 64) begin
        m_done = 1'b1;
        m_val  = (m_crc == 8'h00);
      end
    end
  end

  task automatic check8(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!ended) begin
      check8({req, " crc"},   crc_o,          m_crc);
      check8({req, " done"},  {7'b0, done_o}, {7'b0, m_done});
      check8({req, " valid"}, {7'b0, valid_o},{7'b0, m_val});
    end
  end

  task automatic drive(input bit s, input bit stb, input bit b);
    @(posedge clk); #2;
    start_i = s; bit_stb_i = stb; bit_i = b;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic send_bits(input logic [63:0] w, input int from, input int to, input bit gaps);
    for (int i = from; i < to; i++) begin
      drive(1'b0, 1'b1, w[i]);
      if (gaps && (i % 3 == 0)) idle();
    end
  endtask

  task automatic run_word(input logic [63:0] w, input bit gaps, input bit exp_valid);
    drive(1'b1, 1'b0, 1'b0);
    req = "R2";
    send_bits(w, 0, 56, gaps);
    idle();
    @(negedge clk);
    check8("R3 crc after 56 bits", crc_o, crc_of(w, 56));
    send_bits(w, 56, 64, gaps);
    idle();
    @(negedge clk);
    check8("R4 done at 64", {7'b0, done_o}, 8'h01);
    check8("R4 valid at 64", {7'b0, valid_o}, {7'b0, exp_valid});
  endtask

  logic [63:0] good1, good2, bad, zero_w;

  initial begin
    good1 = {8'h00, 48'h0000_01B8_1C00, 8'h02};
    good1[63:56] = crc_of(good1, 56);
    good2 = {8'h00, 48'hA5C3_9E12_7F40, 8'h33};
    good2[63:56] = crc_of(good2, 56);
    bad = good2 ^ 64'h0000_0000_0100_0000;
    zero_w = 64'h0;

    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    req = "R1";
    idle();
    @(negedge clk);
    check8("R1 reset crc", crc_o, 8'h00);
    check8("R1 reset done", {7'b0, done_o}, 8'h00);

    run_word(good1, 1'b0, 1'b1);
    req = "R5";
    send_bits(64'hFFFF_FFFF_FFFF_FFFF, 0, 10, 1'b0);
    idle();
    @(negedge clk);
    check8("R5 crc after extra strobes", crc_o, 8'h00);
    check8("R5 done kept", {7'b0, done_o}, 8'h01);

    run_word(good2, 1'b1, 1'b1);
    run_word(bad, 1'b0, 1'b0);
    req = "R5";
    send_bits(good2, 0, 5, 1'b0);
    run_word(zero_w, 1'b0, 1'b1);

    // R6: restart in the middle of a word
    drive(1'b1, 1'b0, 1'b0);
    req = "R6";
    send_bits(good2, 0, 20, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    idle();
    @(negedge clk);
    check8("R6 crc cleared", crc_o, 8'h00);
    send_bits(good1, 0, 64, 1'b0);
    idle();
    @(negedge clk);
    check8("R6 restarted word valid", {7'b0, valid_o}, 8'h01);

    // R7: start together with a strobe of a one bit
    req = "R7";
    drive(1'b1, 1'b1, 1'b1);
    idle();
    @(negedge clk);
    check8("R7 strobe with start ignored", crc_o, 8'h00);
    send_bits(good2, 0, 64, 1'b0);
    idle();
    @(negedge clk);
    check8("R7 full word counted after start", {7'b0, valid_o}, 8'h01);

    // R8: gaps hold state
    req = "R8";
    drive(1'b1, 1'b0, 1'b0);
    send_bits(64'h1, 0, 1, 1'b0);
    repeat (4) drive(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check8("R8 crc held over idle", crc_o, crc_step(8'h00, 1'b1));

    req = "R2";
    idle();
    repeat (2) @(posedge clk);
    ended = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!ended) begin
      ended = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule